// File: doc/BRIEF.md
# Byte-Wide Arithmetic and Logic Unit with Status Flags

This block is the execute stage of a small register-machine CPU. Each cycle in which `issue` is high, it takes a 4-bit operation code and two 8-bit operands and evaluates them in one combinational pass. On the same rising edge it latches an 8-bit result together with carry, zero and overflow flags. When `issue` is low, the latched values stay as they are. Fetch, register-field decoding, branching and memory access sit outside the block. A branch unit reads the flags, and the register file takes `result` back as its write data.

The unit covers addition, subtraction, a flag-only compare, three bitwise operations, single-bit left and right shifts, a low-byte multiply and an unsigned divide. Subtraction and compare report carry as "no borrow", so carry high means the first operand is not smaller than the second. Both shifts put the bit they push out into carry. A zero divisor gives an all-ones quotient and does not raise an error.

Top module: `byte_alu`

## Requirements
- R1: After reset, `result` is 0x00 and `flag_c`, `flag_z` and `flag_v` are all 0.
- R2: Opcode 0x0 (add) stores (a + b) mod 256. Carry is the unsigned carry-out. Overflow is set when the signed sum of a and b lies outside -128..127.
- R3: Opcode 0x1 (subtract) stores (a - b) mod 256. Carry is 1 exactly when a >= b (unsigned). Overflow is bit 7 of ((a XOR b) AND (a XOR difference)).
- R4: Opcode 0x9 (compare) sets carry, overflow and zero exactly as opcode 0x1 would, and leaves `result` unchanged.
- R5: Opcodes 0x2, 0x3 and 0x4 store a AND b, a OR b and a XOR b. Carry and overflow are cleared.
- R6: Opcode 0x5 stores a shifted left by one, truncated to 8 bits with a 0 in bit 0. Carry takes the old bit 7 and overflow is cleared.
- R7: Opcode 0x6 stores a logically shifted right by one with a 0 in bit 7. Carry takes the old bit 0 and overflow is cleared.
- R8: Opcode 0x7 stores the low 8 bits of the unsigned product a * b. Carry is set when the upper 8 bits of the product are non-zero, and overflow is cleared.
- R9: Opcode 0x8 stores the unsigned quotient floor(a / b), or 0xFF when b is 0. Carry and overflow are cleared. For example, 100 / 7 gives 14.
- R10: For every opcode, zero is 1 exactly when the 8-bit value the operation produced is 0x00. For compare, that value is the difference a - b.
- R11: Opcodes 0xA to 0xF store operand a unchanged and clear carry and overflow.
- R12: In a cycle with `issue` low, `result` and all three flags keep their previous values whatever the opcode and operands are.
- R13: Outputs change only on the rising clock edge where `issue` is sampled high, so a result is visible one cycle after issue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue | input | 1 | Evaluate and latch the operation on this edge |
| opcode | input | 4 | Operation select |
| opa | input | 8 | First operand (dividend, shifted value, pass-through value) |
| opb | input | 8 | Second operand (divisor, subtrahend) |
| result | output | 8 | Latched result |
| flag_c | output | 1 | Latched carry / no-borrow / ejected bit / product-high flag |
| flag_z | output | 1 | Latched zero flag |
| flag_v | output | 1 | Latched signed overflow flag |

## Verification
The clocked assertions assume that `opcode`, `opa`, `opb` and `issue` are stable around each rising edge. They compare latched outputs with the operands seen one cycle earlier. The bench therefore changes inputs only on the falling edge and holds them for a full cycle. The divider checks assume that a zero divisor is the only case excluded from quotient-remainder recomposition, and the stimulus exercises the zero divisor on its own. The bench computes every expected value with its own integer arithmetic.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  localparam int ALU_W  = 8;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    OP_ADD = 4'h0,
    OP_SUB = 4'h1,
    OP_AND = 4'h2,
    OP_OR  = 4'h3,
    OP_XOR = 4'h4,
    OP_SHL = 4'h5,
    OP_SHR = 4'h6,
    OP_MUL = 4'h7,
    OP_DIV = 4'h8,
    OP_CMP = 4'h9
  } alu_op_e;

  // First code of the pass-through range
  localparam logic [CODE_W-1:0] OP_PASS_LO = 4'hA;

endpackage

// File: rtl/byte_alu_arith.sv
module byte_alu_arith #(
  parameter int W = byte_alu_pkg::ALU_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] add_res,
  output logic         add_c,
  output logic         add_v,
  output logic [W-1:0] sub_res,
  output logic         sub_c,
  output logic         sub_v,
  output logic [W-1:0] mul_res,
  output logic         mul_c
);

  localparam int PW = 2 * W;

  // Signed overflow of a sum: operands agree in sign, result differs
  function automatic logic sum_ovf(input logic [W-1:0] x, input logic [W-1:0] y,
                                   input logic [W-1:0] r);
    logic [W-1:0] t;
    t = ~(x ^ y) & (x ^ r);
    return t[W-1];
  endfunction

  // Signed overflow of a difference: operands differ in sign, result follows subtrahend
  function automatic logic diff_ovf(input logic [W-1:0] x, input logic [W-1:0] y,
                                    input logic [W-1:0] r);
    logic [W-1:0] t;
    t = (x ^ y) & (x ^ r);
    return t[W-1];
  endfunction

  logic [W:0]    sum_wide;
  logic [W:0]    diff_wide;
  logic [PW-1:0] product;
  logic          borrow_out;

  assign sum_wide   = {1'b0, a} + {1'b0, b};
  assign diff_wide  = {1'b0, a} - {1'b0, b};
  assign product    = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  assign borrow_out = diff_wide[W];

  assign add_res = sum_wide[W-1:0];
  assign add_c   = sum_wide[W];
  assign add_v   = sum_ovf(a, b, add_res);

  assign sub_res = diff_wide[W-1:0];
  assign sub_c   = ~borrow_out;
  assign sub_v   = diff_ovf(a, b, sub_res);

  assign mul_res = product[W-1:0];
  assign mul_c   = |product[PW-1:W];

  // R3: no-borrow must agree with an unsigned magnitude compare
  always_comb begin
    a_r3_no_borrow_order: assert (sub_c == (a >= b));
  end

endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic #(
  parameter int W = byte_alu_pkg::ALU_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_res,
  output logic [W-1:0] or_res,
  output logic [W-1:0] xor_res,
  output logic [W-1:0] shl_res,
  output logic         shl_c,
  output logic [W-1:0] shr_res,
  output logic         shr_c
);

  assign and_res = a & b;
  assign or_res  = a | b;
  assign xor_res = a ^ b;

  // Single-position shifts; the bit that leaves becomes carry
  assign shl_res = {a[W-2:0], 1'b0};
  assign shl_c   = a[W-1];
  assign shr_res = {1'b0, a[W-1:1]};
  assign shr_c   = a[0];

  // R6/R7: shifting one way then the other only loses the ejected bit
  always_comb begin
    a_r6_shl_lossless: assert ({shl_c, shl_res} == {a, 1'b0});
    a_r7_shr_lossless: assert ({shr_res, shr_c} == {1'b0, a});
  end

endmodule

// File: rtl/byte_alu_divider.sv
module byte_alu_divider #(
  parameter int W = byte_alu_pkg::ALU_W
) (
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);

  localparam int PW = 2 * W;

  // Restoring division unrolled one stage per quotient bit, MSB first
  logic [W:0]   partial [W];
  logic [W-1:0] carry_rem [W+1];
  logic         take [W];

  assign carry_rem[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_stage
    assign partial[i] = {carry_rem[i], dividend[W-1-i]};
    assign take[i]    = partial[i] >= {1'b0, divisor};
    assign quot[W-1-i] = take[i];
    assign carry_rem[i+1] = take[i] ? W'(partial[i] - {1'b0, divisor})
                                    : partial[i][W-1:0];
  end

  assign rem = carry_rem[W];

  logic [PW-1:0] recomposed;
  assign recomposed = {{W{1'b0}}, quot} * {{W{1'b0}}, divisor} + {{W{1'b0}}, rem};

  // R9: quotient/remainder identity, and all-ones on a zero divisor
  always_comb begin
    a_r9_recompose: assert (divisor == '0 || recomposed == {{W{1'b0}}, dividend});
    a_r9_rem_small: assert (divisor == '0 || rem < divisor);
    a_r9_zero_div:  assert (divisor != '0 || quot == {W{1'b1}});
  end

endmodule

// File: rtl/byte_alu.sv
module byte_alu #(
  parameter int W = byte_alu_pkg::ALU_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue,
  input  logic [3:0]   opcode,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] result,
  output logic         flag_c,
  output logic         flag_z,
  output logic         flag_v
);

  import byte_alu_pkg::*;

  logic [W-1:0] add_res, sub_res, mul_res;
  logic         add_c, add_v, sub_c, sub_v, mul_c;
  logic [W-1:0] and_res, or_res, xor_res, shl_res, shr_res;
  logic         shl_c, shr_c;
  logic [W-1:0] div_q, div_r;

  byte_alu_arith #(.W(W)) u_arith (
    .a(opa), .b(opb),
    .add_res(add_res), .add_c(add_c), .add_v(add_v),
    .sub_res(sub_res), .sub_c(sub_c), .sub_v(sub_v),
    .mul_res(mul_res), .mul_c(mul_c)
  );

  byte_alu_logic #(.W(W)) u_logic (
    .a(opa), .b(opb),
    .and_res(and_res), .or_res(or_res), .xor_res(xor_res),
    .shl_res(shl_res), .shl_c(shl_c),
    .shr_res(shr_res), .shr_c(shr_c)
  );

  byte_alu_divider #(.W(W)) u_div (
    .dividend(opa), .divisor(opb),
    .quot(div_q), .rem(div_r)
  );

  // Named events for the assertions below
  logic [W-1:0] nxt_val;
  logic         nxt_c, nxt_v, nxt_z;
  logic         writes_result;
  logic         is_cmp;

  always_comb begin
    nxt_val       = opa;
    nxt_c         = 1'b0;
    nxt_v         = 1'b0;
    writes_result = 1'b1;
    is_cmp        = 1'b0;
    case (opcode)
      OP_ADD: begin nxt_val = add_res; nxt_c = add_c; nxt_v = add_v; end
      OP_SUB: begin nxt_val = sub_res; nxt_c = sub_c; nxt_v = sub_v; end
      OP_AND: nxt_val = and_res;
      OP_OR:  nxt_val = or_res;
      OP_XOR: nxt_val = xor_res;
      OP_SHL: begin nxt_val = shl_res; nxt_c = shl_c; end
      OP_SHR: begin nxt_val = shr_res; nxt_c = shr_c; end
      OP_MUL: begin nxt_val = mul_res; nxt_c = mul_c; end
      OP_DIV: nxt_val = div_q;
      OP_CMP: begin
        nxt_val = sub_res; nxt_c = sub_c; nxt_v = sub_v;
        writes_result = 1'b0; is_cmp = 1'b1;
      end
      default: nxt_val = opa;
    endcase
    nxt_z = (nxt_val == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      flag_c <= 1'b0;
      flag_z <= 1'b0;
      flag_v <= 1'b0;
    end else if (issue) begin
      if (writes_result) result <= nxt_val;
      flag_c <= nxt_c;
      flag_z <= nxt_z;
      flag_v <= nxt_v;
    end
  end

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> ($stable(result) && $stable(flag_c) && $stable(flag_z) && $stable(flag_v)));

  a_r4_cmp_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && is_cmp) |=> $stable(result));

  a_r10_zero_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !is_cmp) |=> (flag_z == (result == '0)));

  a_r3_sub_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && (opcode == OP_SUB || opcode == OP_CMP)) |=> (flag_c == ($past(opa) >= $past(opb))));

  a_r6_shl_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && opcode == OP_SHL) |=> (flag_c == $past(opa[W-1]) && !flag_v));

  a_r11_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && opcode >= OP_PASS_LO) |=> (result == $past(opa) && !flag_c && !flag_v));

  a_r5_logic_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && opcode inside {OP_AND, OP_OR, OP_XOR, OP_DIV}) |=> (!flag_c && !flag_v));

endmodule

// File: tb/byte_alu_bench.sv
`timescale 1ns/1ps
module byte_alu_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       issue = 1'b0;
  logic [3:0] opcode = 4'h0;
  logic [7:0] opa = 8'h00;
  logic [7:0] opb = 8'h00;
  logic [7:0] result;
  logic       flag_c, flag_z, flag_v;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  byte_alu u_byte_alu (
    .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode),
    .opa(opa), .opb(opb), .result(result),
    .flag_c(flag_c), .flag_z(flag_z), .flag_v(flag_v)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  // Drive on falling edge, latch on rising edge, sample on next falling edge
  task automatic do_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    opcode = op; opa = a; opb = b; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic expect_all(input string tag, input int r, input int c, input int z, input int v);
    check({tag, " result"}, result, r);
    check({tag, " carry"},  flag_c, c);
    check({tag, " zero"},   flag_z, z);
    check({tag, " ovf"},    flag_v, v);
  endtask

  function automatic int sval(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  task automatic t_reset;
    expect_all("R1 reset", 0, 0, 0, 0);
  endtask

  task automatic t_add;
    do_op(4'h0, 8'h7F, 8'h01); expect_all("R2 add 7F+01", 8'h80, 0, 0, 1);
    do_op(4'h0, 8'hFF, 8'h01); expect_all("R2 add FF+01 R10", 8'h00, 1, 1, 0);
    for (int i = 0; i < 256; i += 37) begin
      for (int j = 0; j < 256; j += 53) begin
        int s;
        int ss;
        s  = i + j;
        ss = sval(i) + sval(j);
        do_op(4'h0, 8'(i), 8'(j));
        expect_all("R2 add sweep", s % 256, (s > 255) ? 1 : 0, (s % 256 == 0) ? 1 : 0,
                   (ss > 127 || ss < -128) ? 1 : 0);
      end
    end
  endtask

  task automatic t_sub;
    do_op(4'h1, 8'h05, 8'h07); expect_all("R3 sub 05-07", 8'hFE, 0, 0, 0);
    do_op(4'h1, 8'h80, 8'h01); expect_all("R3 sub 80-01", 8'h7F, 1, 0, 1);
    do_op(4'h1, 8'h07, 8'h07); expect_all("R3 sub equal R10", 8'h00, 1, 1, 0);
    for (int i = 3; i < 256; i += 41) begin
      for (int j = 0; j < 256; j += 47) begin
        int d;
        int sd;
        d  = (i - j + 256) % 256;
        sd = sval(i) - sval(j);
        do_op(4'h1, 8'(i), 8'(j));
        expect_all("R3 sub sweep", d, (i >= j) ? 1 : 0, (d == 0) ? 1 : 0,
                   (sd > 127 || sd < -128) ? 1 : 0);
      end
    end
  endtask

  task automatic t_cmp;
    do_op(4'h0, 8'h20, 8'h13);
    do_op(4'h9, 8'h44, 8'h44); expect_all("R4 cmp equal", 8'h33, 1, 1, 0);
    do_op(4'h9, 8'h10, 8'h90); expect_all("R4 cmp less R10", 8'h33, 0, 0, 1);
    do_op(4'h9, 8'h90, 8'h10); expect_all("R4 cmp greater", 8'h33, 1, 0, 0);
  endtask

  task automatic t_logic_chain;
    do_op(4'h2, 8'hCC, 8'hF0); expect_all("R5 and", 8'hC0, 0, 0, 0);
    do_op(4'h3, 8'hC0, 8'h0F); expect_all("R5 or",  8'hCF, 0, 0, 0);
    do_op(4'h4, 8'hCF, 8'hAA); expect_all("R5 xor", 8'h65, 0, 0, 0);
    do_op(4'h5, 8'h65, 8'h00); expect_all("R6 shl chain", 8'hCA, 0, 0, 0);
    do_op(4'h6, 8'hCA, 8'h00); expect_all("R7 shr chain", 8'h65, 0, 0, 0);
    do_op(4'h4, 8'h5A, 8'h5A); expect_all("R5 xor self R10", 8'h00, 0, 1, 0);
  endtask

  task automatic t_shift_edges;
    do_op(4'h5, 8'h81, 8'hFF); expect_all("R6 shl msb out", 8'h02, 1, 0, 0);
    do_op(4'h5, 8'h80, 8'h00); expect_all("R6 shl to zero", 8'h00, 1, 1, 0);
    do_op(4'h6, 8'h01, 8'h00); expect_all("R7 shr lsb out", 8'h00, 1, 1, 0);
    do_op(4'h6, 8'hFE, 8'h00); expect_all("R7 shr logical", 8'h7F, 0, 0, 0);
  endtask

  task automatic t_mul;
    do_op(4'h7, 8'd12, 8'd10); expect_all("R8 mul small", 120, 0, 0, 0);
    do_op(4'h7, 8'd16, 8'd16); expect_all("R8 mul wrap R10", 0, 1, 1, 0);
    do_op(4'h7, 8'hFF, 8'hFF); expect_all("R8 mul max", 8'h01, 1, 0, 0);
  endtask

  task automatic t_div;
    do_op(4'h8, 8'd100, 8'd7); expect_all("R9 div 100/7", 14, 0, 0, 0);
    do_op(4'h8, 8'd5, 8'd0);   expect_all("R9 div by zero", 8'hFF, 0, 0, 0);
    do_op(4'h8, 8'd0, 8'd3);   expect_all("R9 div zero num R10", 0, 0, 1, 0);
    do_op(4'h8, 8'd255, 8'd1); expect_all("R9 div by one", 255, 0, 0, 0);
    do_op(4'h8, 8'd6, 8'd200); expect_all("R9 div small", 0, 0, 1, 0);
  endtask

  task automatic t_pass;
    for (int k = 10; k < 16; k++) begin
      do_op(4'(k), 8'(k * 17), 8'hFF);
      expect_all("R11 pass", (k * 17) % 256, 0, 0, 0);
    end
    do_op(4'hF, 8'h00, 8'h01); expect_all("R11 pass zero", 0, 0, 1, 0);
  endtask

  task automatic t_hold;
    do_op(4'h0, 8'hFF, 8'h02);
    expect_all("R13 setup", 8'h01, 1, 0, 0);
    @(negedge clk);
    opcode = 4'h1; opa = 8'h00; opb = 8'h55; issue = 1'b0;
    @(negedge clk);
    @(negedge clk);
    expect_all("R12 hold", 8'h01, 1, 0, 0);
    issue = 1'b1;
    @(posedge clk);
    #1;
    check("R13 change after edge", result, 8'hAB);
    @(negedge clk);
    issue = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_add();
    t_sub();
    t_cmp();
    t_logic_chain();
    t_shift_edges();
    t_mul();
    t_div();
    t_pass();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule